// File: doc/BRIEF.md
# Indexed Block-Transfer Configuration Register Slave

This block is a two-wire serial slave that lets a host read and write a small bank of 8-bit configuration registers. Both lines are sampled by the system clock, brought through a two-flop synchroniser and a level filter, and then watched for edges. START, repeated START and STOP are decoded from data-line edges seen while the clock line is high.

Every access opens with the write address, followed by a starting register index. A write then carries a byte count and that many data bytes. A read sends a repeated START and the read address. The slave answers with the byte count held in its own count register and then the data bytes. The register index advances after each data byte and wraps at the end of the bank. Register contents are exported on a flat vector for the surrounding logic to use. The open-drain pad and clock stretching sit outside this block. The block only asks for the data line to be pulled low.

Top module: `smbreg_slave`

## Requirements
- R1: An address byte of 0xD2 (write) or 0xD3 (read) is acknowledged. Any other address byte is not acknowledged, and the slave keeps the data line released and leaves every register unchanged until the next START.
- R2: A write transaction sends 0xD2, then an index N, then a count X, then data bytes. The slave acknowledges every one of these bytes and stores the data bytes into registers N, N+1, and so on.
- R3: Data bytes written beyond the count X are not acknowledged and are not stored. A count of zero stores nothing.
- R4: A read transaction sends 0xD2, then index N, then a repeated START, then 0xD3. The slave then sends the value of the count register, followed by that many bytes taken from registers N onward. Any byte the master clocks beyond that length reads as 0xFF.
- R5: Register 8 is the read length register. It is fully writable and resets to 0x08.
- R6: Register 0 is read-only and always holds 0x5A. In every odd-numbered register other than 0, bits 7..4 are reserved: they read as zero and ignore writes. All other bits of all other registers are writable.
- R7: The register index counts modulo 16. Only the low four bits of the index byte are used, and the index advances after each stored or sent data byte, wrapping from 15 to 0.
- R8: A STOP or START that arrives part way through a byte abandons the transaction. Bytes already acknowledged stay stored, and the partial byte is dropped.
- R9: A repeated START keeps the index set earlier in the same transaction.
- R10: After reset, every register holds its reset value: 0x5A in register 0, 0x08 in register 8, and zero elsewhere. The data line is released.
- R11: When the master does not acknowledge a read byte, the slave releases the data line and stays silent until the next START or STOP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples both bus lines |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad (wired level) |
| sdaDriveLow | output | 1 | 1 requests the pad to pull the data line low |
| cfgFlat | output | 128 | Register contents, register i in bits 8i+7..8i |

## Verification
The properties assume a well-formed bus in which the data line changes only while the clock line is low, except for START and STOP. They also assume each line level lasts longer than the synchroniser plus filter delay. Only under those assumptions do the slave's own data-line changes fall in clock-low time. The stimulus bit-bangs the bus from a master model that holds every level for twelve system clocks and never moves both lines together. The one mid-byte abort it drives is produced by a correctly formed START or STOP.

// File: rtl/smbreg_pkg.sv
package smbreg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_INDEX, ST_WCNT, ST_WDATA, ST_RCNT, ST_RDATA, ST_SKIP
  } smbState_t;

  // strobes from the bus controller to the register datapath
  typedef struct packed {
    logic loadIdx;    // take index from received byte
    logic loadRemRx;  // remaining length from received count byte
    logic loadRemCnt; // remaining length from the count register
    logic wrByte;     // store received byte at the current index
    logic step;       // advance index, decrement remaining length
  } smbStrobe_t;

  function automatic logic [7:0] writeMask(int i, int roIdx, int cntIdx);
    if (i == roIdx) return 8'h00;
    if (i == cntIdx) return 8'hFF;
    if (i % 2 == 1) return 8'h0F;
    return 8'hFF;
  endfunction

  function automatic logic [7:0] resetValue(int i, int roIdx, int cntIdx,
                                            logic [7:0] idVal, logic [7:0] cntRst);
    if (i == roIdx) return idVal;
    if (i == cntIdx) return cntRst;
    return 8'h00;
  endfunction

endpackage

// File: rtl/smbreg_ctrl.sv
module smbreg_ctrl
  import smbreg_pkg::*;
#(
  parameter int         FILT_LEN = 3,
  parameter logic [7:0] WR_ADDR  = 8'hD2,
  parameter logic [7:0] RD_ADDR  = 8'hD3
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [7:0] txData,
  input  logic [7:0] cntVal,
  input  logic       remZero,
  output smbStrobe_t strb,
  output logic [7:0] rxByte,
  output logic       sdaDriveLow,
  output logic       sclLevel,
  output smbState_t  stateOut
);

  logic [1:0] sclSync, sdaSync;
  logic [FILT_LEN-1:0] sclHist, sdaHist;
  logic sclF, sdaF, sclPrev, sdaPrev;

  // synchronise and filter both lines
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclSync <= '1; sdaSync <= '1;
      sclHist <= '1; sdaHist <= '1;
      sclF <= 1'b1; sdaF <= 1'b1;
      sclPrev <= 1'b1; sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclHist <= {sclHist[FILT_LEN-2:0], sclSync[1]};
      sdaHist <= {sdaHist[FILT_LEN-2:0], sdaSync[1]};
      if (&sclHist) sclF <= 1'b1; else if (~|sclHist) sclF <= 1'b0;
      if (&sdaHist) sdaF <= 1'b1; else if (~|sdaHist) sdaF <= 1'b0;
      sclPrev <= sclF;
      sdaPrev <= sdaF;
    end
  end

  logic sclRise, sclFall, startEv, stopEv;
  assign sclRise = sclF & ~sclPrev;
  assign sclFall = ~sclF & sclPrev;
  assign startEv = sclF & sclPrev & sdaPrev & ~sdaF;
  assign stopEv  = sclF & sclPrev & ~sdaPrev & sdaF;

  smbState_t  state;
  logic [3:0] bitCnt;
  logic       inAck, isRead, mAck, driveLow;
  logic [7:0] shReg, txByte;
  logic       isTx;
  assign isTx = (state == ST_RCNT) || (state == ST_RDATA);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE; bitCnt <= '0; inAck <= 1'b0; isRead <= 1'b0;
      mAck <= 1'b0; driveLow <= 1'b0; shReg <= '0; txByte <= '0; strb <= '0;
    end else begin
      strb <= '0;
      if (stopEv) begin
        state <= ST_IDLE; driveLow <= 1'b0;
      end else if (startEv) begin
        state <= ST_ADDR; bitCnt <= '0; inAck <= 1'b0; driveLow <= 1'b0;
      end else if (state != ST_IDLE && state != ST_SKIP) begin
        if (sclRise) begin
          if (inAck) mAck <= ~sdaF;
          else begin
            bitCnt <= bitCnt + 4'd1;
            shReg  <= {shReg[6:0], sdaF};
          end
        end else if (sclFall) begin
          if (!inAck && bitCnt == 4'd8) begin
            // ninth bit begins: acknowledge a received byte or release for the master
            inAck    <= 1'b1;
            driveLow <= 1'b0;
            case (state)
              ST_ADDR:
                if (shReg == WR_ADDR) begin driveLow <= 1'b1; isRead <= 1'b0; end
                else if (shReg == RD_ADDR) begin driveLow <= 1'b1; isRead <= 1'b1; end
                else state <= ST_SKIP;
              ST_INDEX: begin driveLow <= 1'b1; strb.loadIdx <= 1'b1; end
              ST_WCNT:  begin driveLow <= 1'b1; strb.loadRemRx <= 1'b1; end
              ST_WDATA:
                if (!remZero) begin
                  driveLow <= 1'b1; strb.wrByte <= 1'b1; strb.step <= 1'b1;
                end else state <= ST_SKIP;
              default: ;
            endcase
          end else if (inAck) begin
            // ninth bit ends: move to the next byte
            inAck    <= 1'b0;
            bitCnt   <= '0;
            driveLow <= 1'b0;
            case (state)
              ST_ADDR:
                if (isRead) begin
                  state <= ST_RCNT; txByte <= cntVal; driveLow <= ~cntVal[7];
                  strb.loadRemCnt <= 1'b1;
                end else state <= ST_INDEX;
              ST_INDEX: state <= ST_WCNT;
              ST_WCNT:  state <= ST_WDATA;
              ST_RCNT, ST_RDATA:
                if (mAck) begin
                  state <= ST_RDATA;
                  if (remZero) txByte <= 8'hFF;
                  else begin
                    txByte <= txData; driveLow <= ~txData[7]; strb.step <= 1'b1;
                  end
                end else state <= ST_SKIP;
              default: ;
            endcase
          end else if (isTx && bitCnt != 4'd0) begin
            driveLow <= ~txByte[3'd7 - bitCnt[2:0]];
          end
        end
      end
    end
  end

  assign rxByte      = shReg;
  assign sdaDriveLow = driveLow;
  assign sclLevel    = sclF;
  assign stateOut    = state;

endmodule

// File: rtl/smbreg_bank.sv
module smbreg_bank
  import smbreg_pkg::*;
#(
  parameter int         NUM_REGS = 16,
  parameter int         RO_IDX   = 0,
  parameter int         CNT_IDX  = 8,
  parameter logic [7:0] ID_VAL   = 8'h5A,
  parameter logic [7:0] CNT_RST  = 8'h08
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  smbStrobe_t            strb,
  input  logic [7:0]            rxByte,
  output logic [7:0]            rdByte,
  output logic [7:0]            cntVal,
  output logic [7:0]            remCnt,
  output logic                  remZero,
  output logic [NUM_REGS*8-1:0] cfgFlat
);

  localparam int IDX_W = $clog2(NUM_REGS);

  logic [IDX_W-1:0] idx;
  logic [7:0]       regVal [NUM_REGS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idx <= '0; remCnt <= '0;
    end else begin
      if (strb.loadIdx) idx <= rxByte[IDX_W-1:0];
      else if (strb.step) idx <= idx + 1'b1;
      if (strb.loadRemRx) remCnt <= rxByte;
      else if (strb.loadRemCnt) remCnt <= cntVal;
      else if (strb.step && remCnt != 8'd0) remCnt <= remCnt - 8'd1;
    end
  end

  for (genvar gi = 0; gi < NUM_REGS; gi++) begin : g_reg
    localparam logic [7:0] MASK = writeMask(gi, RO_IDX, CNT_IDX);
    localparam logic [7:0] RSTV = resetValue(gi, RO_IDX, CNT_IDX, ID_VAL, CNT_RST);
    if (MASK == 8'h00) begin : g_const
      assign regVal[gi] = RSTV;
    end else begin : g_store
      logic [7:0] q;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) q <= RSTV;
        else if (strb.wrByte && idx == IDX_W'(gi)) q <= (rxByte & MASK) | (q & ~MASK);
      end
      assign regVal[gi] = q;
    end
    assign cfgFlat[gi*8 +: 8] = regVal[gi];
  end

  assign rdByte  = regVal[idx];
  assign cntVal  = regVal[CNT_IDX];
  assign remZero = (remCnt == 8'd0);

endmodule

// File: rtl/smbreg_slave.sv
module smbreg_slave
  import smbreg_pkg::*;
#(
  parameter int         NUM_REGS = 16,
  parameter int         FILT_LEN = 3,
  parameter logic [7:0] WR_ADDR  = 8'hD2,
  parameter logic [7:0] RD_ADDR  = 8'hD3,
  parameter int         RO_IDX   = 0,
  parameter int         CNT_IDX  = 8,
  parameter logic [7:0] ID_VAL   = 8'h5A,
  parameter logic [7:0] CNT_RST  = 8'h08
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  sclIn,
  input  logic                  sdaIn,
  output logic                  sdaDriveLow,
  output logic [NUM_REGS*8-1:0] cfgFlat
);

  smbStrobe_t strb;
  smbState_t  ctrlState;
  logic [7:0] rxByte, rdByte, cntVal, remCnt;
  logic       remZero, sclLevel;

  smbreg_ctrl #(.FILT_LEN(FILT_LEN), .WR_ADDR(WR_ADDR), .RD_ADDR(RD_ADDR)) ctrlU (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .txData(rdByte), .cntVal(cntVal), .remZero(remZero),
    .strb(strb), .rxByte(rxByte), .sdaDriveLow(sdaDriveLow),
    .sclLevel(sclLevel), .stateOut(ctrlState)
  );

  smbreg_bank #(.NUM_REGS(NUM_REGS), .RO_IDX(RO_IDX), .CNT_IDX(CNT_IDX),
                .ID_VAL(ID_VAL), .CNT_RST(CNT_RST)) bankU (
    .clk(clk), .rstN(rstN), .strb(strb), .rxByte(rxByte),
    .rdByte(rdByte), .cntVal(cntVal), .remCnt(remCnt), .remZero(remZero),
    .cfgFlat(cfgFlat)
  );

endmodule

// File: rtl/smbreg_slave_chk.sv
module smbreg_slave_chk
  import smbreg_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       sdaDriveLow,
  input logic       sclLevel,
  input smbState_t  ctrlState,
  input smbStrobe_t strb,
  input logic [7:0] remCnt,
  input logic       remZero
);

  // R2: the slave moves the data line only while the filtered clock is low
  p_drive_on_low_scl_r2: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !sclLevel);

  // R1: once ignoring traffic, the data line stays released
  p_skip_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlState == ST_SKIP && $past(ctrlState) == ST_SKIP) |-> !sdaDriveLow);

  // R3: no store once the announced count is used up
  p_write_within_count_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrByte |-> !remZero);

  // R3: each transferred data byte consumes one unit of the remaining length
  p_count_steps_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.step && !strb.loadRemRx && !strb.loadRemCnt) |=> remCnt == $past(remCnt) - 8'd1);

  // R8: after STOP the line is released
  p_idle_released_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctrlState == ST_IDLE |-> !sdaDriveLow);

endmodule

bind smbreg_slave smbreg_slave_chk chkU (
  .clk(clk), .rstN(rstN), .sdaDriveLow(sdaDriveLow), .sclLevel(sclLevel),
  .ctrlState(ctrlState), .strb(strb), .remCnt(remCnt), .remZero(remZero)
);

// File: tb/smbreg_slave_tb_top.sv
module smbreg_slave_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 12;
  localparam int NREG       = 16;
  localparam int WATCH      = 190000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic sdaDriveLow;
  logic [NREG*8-1:0] cfgFlat;
  logic sdaBus;

  assign sdaBus = mSda & ~sdaDriveLow;

  always #(CLK_PERIOD/2) clk = ~clk;

  smbreg_slave dut_i (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus),
    .sdaDriveLow(sdaDriveLow), .cfgFlat(cfgFlat)
  );

  int checks = 0, errors = 0;
  logic [7:0] model [NREG];
  logic [7:0] wbuf [32];

  function automatic logic [7:0] maskOf(int i);
    if (i == 0) return 8'h00;
    if (i == 8) return 8'hFF;
    return (i % 2 == 1) ? 8'h0F : 8'hFF;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    for (int i = 0; i < NREG; i++) chk(tag, 32'(cfgFlat[i*8 +: 8]), 32'(model[i]));
  endtask

  task automatic wt; repeat (HALF) @(posedge clk); endtask

  task automatic startCond;
    mSda = 1'b1; wt; mScl = 1'b1; wt; mSda = 1'b0; wt; mScl = 1'b0; wt;
  endtask

  task automatic stopCond;
    mSda = 1'b0; wt; mScl = 1'b1; wt; mSda = 1'b1; wt;
  endtask

  task automatic sendBit(input logic b);
    mSda = b; wt; mScl = 1'b1; wt; mScl = 1'b0; wt;
  endtask

  task automatic getBit(output logic b);
    mSda = 1'b1; wt; mScl = 1'b1; wt; @(negedge clk); b = sdaBus; wt; mScl = 1'b0; wt;
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic bt;
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    getBit(bt);
    ack = ~bt;
  endtask

  task automatic recvByte(output logic [7:0] v, input logic giveAck);
    logic bt;
    for (int i = 7; i >= 0; i--) begin getBit(bt); v[i] = bt; end
    sendBit(~giveAck);
  endtask

  // write: index idx, count cnt, nSend data bytes from wbuf
  task automatic doWrite(input int idx, input int cnt, input int nSend, input string tag);
    logic ack;
    startCond;
    sendByte(8'hD2, ack); chk({tag, " R1 write address ack"}, 32'(ack), 1);
    sendByte(8'(idx), ack); chk({tag, " R2 index ack"}, 32'(ack), 1);
    sendByte(8'(cnt), ack); chk({tag, " R2 count ack"}, 32'(ack), 1);
    for (int k = 0; k < nSend; k++) begin
      sendByte(wbuf[k], ack);
      if (k < cnt) begin
        chk({tag, " R2 data ack"}, 32'(ack), 1);
        model[(idx + k) % NREG] = (wbuf[k] & maskOf((idx + k) % NREG)) |
                                  (model[(idx + k) % NREG] & ~maskOf((idx + k) % NREG));
      end else chk({tag, " R3 extra byte nack"}, 32'(ack), 0);
    end
    stopCond;
    wt;
  endtask

  task automatic doRead(input int idx, input int nData, input string tag);
    logic ack;
    logic [7:0] v;
    int len;
    startCond;
    sendByte(8'hD2, ack); chk({tag, " R1 address ack"}, 32'(ack), 1);
    sendByte(8'(idx), ack); chk({tag, " R9 index ack"}, 32'(ack), 1);
    startCond;
    sendByte(8'hD3, ack); chk({tag, " R1 read address ack"}, 32'(ack), 1);
    len = int'(model[8]);
    recvByte(v, 1'b1); chk({tag, " R5 count byte"}, 32'(v), 32'(model[8]));
    for (int k = 0; k < nData; k++) begin
      recvByte(v, k < nData - 1);
      if (k < len) chk({tag, " R4 R7 R9 data byte"}, 32'(v), 32'(model[(idx + k) % NREG]));
      else chk({tag, " R4 past length"}, 32'(v), 32'hFF);
    end
    chk({tag, " R11 released after nack"}, 32'(sdaDriveLow), 0);
    stopCond;
    wt;
  endtask

  logic finished = 1'b0;

  initial begin : main
    logic ack;
    for (int i = 0; i < NREG; i++) model[i] = (i == 0) ? 8'h5A : (i == 8) ? 8'h08 : 8'h00;
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R10 sda released in reset", 32'(sdaDriveLow), 0);
    rstN = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    checkAll("R10 reset values");

    // R2 R6: block write with masks
    wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'h77; wbuf[3] = 8'hE1;
    doWrite(1, 4, 4, "blk");
    checkAll("R2 R6 block write");

    // R6: read-only register
    wbuf[0] = 8'hFF;
    doWrite(0, 1, 1, "ro");
    checkAll("R6 read-only");

    // R5 R4: set length 3, read 5 from index 1
    wbuf[0] = 8'h03;
    doWrite(8, 1, 1, "len");
    chk("R5 count register", 32'(cfgFlat[8*8 +: 8]), 3);
    doRead(1, 5, "rd");

    // R7: wrap
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
    doWrite(14, 4, 4, "wrap");
    checkAll("R7 wrap write");

    // R3: extra bytes and zero count
    wbuf[0] = 8'h5C; wbuf[1] = 8'hC5; wbuf[2] = 8'h99;
    doWrite(2, 1, 3, "extra");
    doWrite(4, 0, 2, "zero");
    checkAll("R3 count limit");

    // R1: wrong address ignored
    startCond;
    sendByte(8'hA0, ack); chk("R1 foreign address nack", 32'(ack), 0);
    sendByte(8'h06, ack); chk("R1 ignored byte nack", 32'(ack), 0);
    sendByte(8'h01, ack); chk("R1 ignored byte nack", 32'(ack), 0);
    sendByte(8'hEE, ack); chk("R1 ignored byte nack", 32'(ack), 0);
    stopCond; wt;
    checkAll("R1 no change");

    // R8: abort by STOP mid byte
    startCond;
    sendByte(8'hD2, ack); sendByte(8'h05, ack); sendByte(8'h03, ack);
    sendByte(8'h99, ack); chk("R8 first byte ack", 32'(ack), 1);
    model[5] = (8'h99 & 8'h0F) | (model[5] & 8'hF0);
    for (int i = 0; i < 4; i++) sendBit(1'(i % 2));
    stopCond; wt;
    checkAll("R8 stop abort");
    // R8: abort by START mid byte
    startCond;
    sendByte(8'hD2, ack); sendByte(8'h06, ack); sendByte(8'h02, ack);
    for (int i = 0; i < 3; i++) sendBit(1'b1);
    startCond;
    stopCond; wt;
    checkAll("R8 start abort");

    // sweep: every register, then read all with length 16
    for (int i = 0; i < NREG; i++) begin
      if (i != 8) begin
        wbuf[0] = 8'((i * 37 + 11) & 255);
        doWrite(i, 1, 1, "sweep");
      end
    end
    wbuf[0] = 8'd16;
    doWrite(8, 1, 1, "len16");
    checkAll("R2 R6 sweep");
    doRead(0, 16, "rdall");
    doRead(9, 17, "rdwrap");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : watchdog
    repeat (WATCH) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule